// File: doc/BRIEF.md
# Scatter-Gather Channel Run and Event Controller

This block controls one scatter-gather DMA channel. Software programs it through a small word-addressed register port. It starts and stops a descriptor engine through a single go line. It also watches the engine's per-descriptor event pulses and its busy flag. Engine events whose enable is set are recorded in a sticky status register. An interrupt line follows the unmasked part of that register.

Two kinds of stop exist. An enabled error halts the engine at once. Clearing the run bit is a soft stop: the descriptor in progress finishes first. Either kind of stop produces an idle-stopped event.

The block counts completed descriptors. When poll-mode writeback is enabled, every descriptor that finishes with its completion flag set produces a one-cycle writeback request carrying the running count. Two further control bits pass straight to the data path as static configuration: fixed (non-incrementing) read addressing, and suppression of stream completion writeback.

Top module: `dma_chan_ctl`

## Requirements
- R1: Writing control bit 0 (run) to 1 while it reads 0 asserts `eng_go` after that write's clock edge and clears the completed-descriptor counter. Writing 1 while it is already 1 does nothing.
- R2: With `eng_busy` low, clearing run drops `eng_go` within two cycles and raises the idle-stopped event.
- R3: With `eng_busy` high, clearing run keeps `eng_go` asserted until the next `ev_desc_done` pulse. `eng_go` then drops and the idle-stopped event is raised.
- R4: Each error has a 5-bit enable field: read error at control bits 13:9, write error at 18:14, descriptor error at 23:19. When the field is all ones, the error sets its status bit and halts the engine (`eng_go` low, idle-stopped raised). Any other field value leaves `eng_go` and the status bit unchanged.
- R5: Control bits 1..6 enable six events, which set status bits 0..5: descriptor-stopped, descriptor-completed (done pulse with the completion flag), align-mismatch, magic-stopped, invalid-length and idle-stopped. The error status bits are 6 (read), 7 (write) and 8 (descriptor). A disabled event leaves the status register unchanged.
- R6: Status bits are sticky. Writing 1 to a bit at word address 1 clears it, and an event in the same cycle wins over the clear.
- R7: `irq` is the registered OR of status ANDed with the mask register at word address 2.
- R8: When control bit 26 is set, each `ev_desc_done` with `ev_desc_cpl` produces a one-cycle `wb_req` whose `wb_count` is the completed-descriptor count including that descriptor. When bit 26 is clear, no request is made. The count is readable at word address 3.
- R9: Control (word address 0) reads back every written field. Bits 31:28, 24 and 8:7 always read 0. `cfg_rd_fixed` follows bit 25 and `cfg_stream_wb_off` follows bit 27.
- R10: After reset, every register, `eng_go`, `irq` and `wb_req` are 0. Read data appears one cycle after `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| eng_busy | input | 1 | Engine has a descriptor in flight |
| ev_desc_done | input | 1 | Descriptor finished (pulse) |
| ev_desc_cpl | input | 1 | Finished descriptor carried the completion flag |
| ev_desc_stop | input | 1 | Descriptor-stopped event |
| ev_align | input | 1 | Alignment mismatch event |
| ev_magic | input | 1 | Bad magic stop event |
| ev_badlen | input | 1 | Invalid length event |
| err_read | input | 1 | Read error pulse |
| err_write | input | 1 | Write error pulse |
| err_desc | input | 1 | Descriptor error pulse |
| eng_go | output | 1 | Engine may run |
| cfg_rd_fixed | output | 1 | Non-incrementing read address |
| cfg_stream_wb_off | output | 1 | Stream completion writeback disabled |
| wb_req | output | 1 | Poll-mode writeback request |
| wb_count | output | CNT_W | Completed descriptor count for the writeback |
| irq | output | 1 | Interrupt |

## Verification
Some properties are checked on every cycle by assertions:
- `eng_go` rises only after a run start.
- An enabled error forces `eng_go` low.
- `eng_go` stays up during a soft stop while no descriptor has finished.
- Status bits never drop without a clear write.
- `wb_req` appears only for a completion-flagged descriptor with poll mode on.

Other behaviour needs the bench's scenarios:
- the exact count carried by each writeback request (compared through a scoreboard queue);
- the rejection of error fields that are not all ones;
- readback masking of reserved bits;
- the counter restart on a new run.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int CTRL_W  = 32;
  localparam int ERR_EN_W = 5;
  localparam int NUM_EV  = 6;
  localparam int NUM_ERR = 3;
  localparam int STS_W   = NUM_EV + NUM_ERR;

  // control bit positions (software contract)
  localparam int C_RUN        = 0;
  localparam int C_EV_LSB     = 1;
  localparam int C_RDERR_LSB  = 9;
  localparam int C_WRERR_LSB  = 14;
  localparam int C_DSERR_LSB  = 19;
  localparam int C_RD_FIXED   = 25;
  localparam int C_POLL_WB    = 26;
  localparam int C_STRM_WBOFF = 27;

  localparam logic [CTRL_W-1:0] CTRL_WMASK = 32'h0EFF_FE7F;

  // status bit positions
  localparam int S_DESC_STOP = 0;
  localparam int S_DESC_CPL  = 1;
  localparam int S_ALIGN     = 2;
  localparam int S_MAGIC     = 3;
  localparam int S_BADLEN    = 4;
  localparam int S_IDLE_STOP = 5;
  localparam int S_RDERR     = 6;
  localparam int S_WRERR     = 7;
  localparam int S_DSERR     = 8;

  // word addresses
  localparam int A_CTRL  = 0;
  localparam int A_STS   = 1;
  localparam int A_MASK  = 2;
  localparam int A_COUNT = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } run_st_e;
endpackage

// File: rtl/chan_ctrl_reg.sv
module chan_ctrl_reg
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              run_start
);
  logic ctrl_we;

  assign ctrl_we   = wr_en && (addr == ADDR_W'(A_CTRL));
  assign run_start = ctrl_we && wdata[C_RUN] && !ctrl_q[C_RUN];

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= wdata & CTRL_WMASK;
  end

  // a start pulse must be followed by run reading 1
  AST_START_SETS_RUN: assert property (@(posedge clk) disable iff (rst)
    run_start |=> ctrl_q[C_RUN]); // R1
endmodule

// File: rtl/chan_status.sv
module chan_status
  import dma_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl_q,
  input  logic              ev_desc_stop,
  input  logic              ev_desc_cpl_done,
  input  logic              ev_align,
  input  logic              ev_magic,
  input  logic              ev_badlen,
  input  logic              ev_idle_stop,
  input  logic              err_read,
  input  logic              err_write,
  input  logic              err_desc,
  input  logic              clr_we,
  input  logic [STS_W-1:0]  clr_bits,
  input  logic              mask_we,
  input  logic [STS_W-1:0]  mask_data,
  output logic [STS_W-1:0]  sts_q,
  output logic [STS_W-1:0]  mask_q,
  output logic              irq_q,
  output logic              err_halt
);
  localparam int ERR_LSB [NUM_ERR] = '{C_RDERR_LSB, C_WRERR_LSB, C_DSERR_LSB};

  logic [NUM_EV-1:0]  ev_raw;
  logic [NUM_ERR-1:0] err_raw;
  logic [NUM_ERR-1:0] err_hit;
  logic [NUM_EV-1:0]  ev_hit;
  logic [STS_W-1:0]   set_vec;
  logic [STS_W-1:0]   clr_vec;

  assign ev_raw  = {ev_idle_stop, ev_badlen, ev_magic, ev_align, ev_desc_cpl_done, ev_desc_stop};
  assign err_raw = {err_desc, err_write, err_read};

  for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
    assign ev_hit[e] = ev_raw[e] && ctrl_q[C_EV_LSB + e];
  end

  for (genvar k = 0; k < NUM_ERR; k++) begin : g_err
    assign err_hit[k] = err_raw[k] && (&ctrl_q[ERR_LSB[k] +: ERR_EN_W]);
  end

  assign set_vec  = {err_hit, ev_hit};
  assign clr_vec  = clr_we ? clr_bits : '0;
  assign err_halt = |err_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~clr_vec) | set_vec;
      if (mask_we) mask_q <= mask_data;
      irq_q <= |(sts_q & mask_q);
    end
  end

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !clr_we |=> (($past(sts_q) & ~sts_q) == '0)); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) && $stable(mask_q) |=> !irq_q); // R7
endmodule

// File: rtl/chan_run_fsm.sv
module chan_run_fsm
  import dma_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_start,
  input  logic             run_level,
  input  logic             poll_en,
  input  logic             eng_busy,
  input  logic             desc_done,
  input  logic             desc_cpl,
  input  logic             err_halt,
  output logic             go_q,
  output logic             stop_ev_q,
  output logic             wb_req_q,
  output logic [CNT_W-1:0] wb_cnt_q,
  output logic [CNT_W-1:0] done_cnt_q
);
  run_st_e    st_q, st_d;
  logic       stop_d;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = done_cnt_q + CNT_W'(1);

  always_comb begin
    st_d   = st_q;
    stop_d = 1'b0;
    if (run_start) begin
      st_d = ST_RUN;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (err_halt) begin
            st_d = ST_IDLE; stop_d = 1'b1;
          end else if (!run_level) begin
            if (eng_busy && !desc_done) st_d = ST_DRAIN;
            else begin st_d = ST_IDLE; stop_d = 1'b1; end
          end
        end
        ST_DRAIN: begin
          if (err_halt || desc_done) begin
            st_d = ST_IDLE; stop_d = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      go_q       <= 1'b0;
      stop_ev_q  <= 1'b0;
      wb_req_q   <= 1'b0;
      wb_cnt_q   <= '0;
      done_cnt_q <= '0;
    end else begin
      st_q      <= st_d;
      go_q      <= (st_d != ST_IDLE);
      stop_ev_q <= stop_d;
      wb_req_q  <= poll_en && desc_done && desc_cpl;
      if (run_start)      done_cnt_q <= '0;
      else if (desc_done) done_cnt_q <= cnt_inc;
      if (desc_done && !run_start) wb_cnt_q <= cnt_inc;
    end
  end

  AST_GO_ONLY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    $rose(go_q) |-> $past(run_start)); // R1
  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (rst)
    (err_halt && !run_start) |=> !go_q); // R4
  AST_DRAIN_HOLDS_GO: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DRAIN && !desc_done && !err_halt) |=> go_q); // R3
  AST_WB_ONLY_POLL: assert property (@(posedge clk) disable iff (rst)
    wb_req_q |-> $past(poll_en && desc_done && desc_cpl)); // R8
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              eng_busy,
  input  logic              ev_desc_done,
  input  logic              ev_desc_cpl,
  input  logic              ev_desc_stop,
  input  logic              ev_align,
  input  logic              ev_magic,
  input  logic              ev_badlen,
  input  logic              err_read,
  input  logic              err_write,
  input  logic              err_desc,
  output logic              eng_go,
  output logic              cfg_rd_fixed,
  output logic              cfg_stream_wb_off,
  output logic              wb_req,
  output logic [CNT_W-1:0]  wb_count,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              run_start;
  logic [STS_W-1:0]  sts_q, mask_q;
  logic              err_halt, stop_ev;
  logic [CNT_W-1:0]  done_cnt;
  logic              sts_we, mask_we;

  assign sts_we  = reg_wr && (reg_addr == ADDR_W'(A_STS));
  assign mask_we = reg_wr && (reg_addr == ADDR_W'(A_MASK));

  chan_ctrl_reg #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .ctrl_q(ctrl_q), .run_start(run_start)
  );

  chan_status i_sts (
    .clk(clk), .rst(rst), .ctrl_q(ctrl_q),
    .ev_desc_stop(ev_desc_stop), .ev_desc_cpl_done(ev_desc_done && ev_desc_cpl),
    .ev_align(ev_align), .ev_magic(ev_magic), .ev_badlen(ev_badlen),
    .ev_idle_stop(stop_ev), .err_read(err_read), .err_write(err_write),
    .err_desc(err_desc), .clr_we(sts_we), .clr_bits(reg_wdata[STS_W-1:0]),
    .mask_we(mask_we), .mask_data(reg_wdata[STS_W-1:0]),
    .sts_q(sts_q), .mask_q(mask_q), .irq_q(irq), .err_halt(err_halt)
  );

  chan_run_fsm #(.CNT_W(CNT_W)) i_fsm (
    .clk(clk), .rst(rst), .run_start(run_start), .run_level(ctrl_q[C_RUN]),
    .poll_en(ctrl_q[C_POLL_WB]), .eng_busy(eng_busy), .desc_done(ev_desc_done),
    .desc_cpl(ev_desc_cpl), .err_halt(err_halt), .go_q(eng_go),
    .stop_ev_q(stop_ev), .wb_req_q(wb_req), .wb_cnt_q(wb_count),
    .done_cnt_q(done_cnt)
  );

  assign cfg_rd_fixed      = ctrl_q[C_RD_FIXED];
  assign cfg_stream_wb_off = ctrl_q[C_STRM_WBOFF];

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) begin
      unique case (reg_addr)
        ADDR_W'(A_CTRL):  reg_rdata <= ctrl_q;
        ADDR_W'(A_STS):   reg_rdata <= 32'(sts_q);
        ADDR_W'(A_MASK):  reg_rdata <= 32'(mask_q);
        ADDR_W'(A_COUNT): reg_rdata <= 32'(done_cnt);
        default:          reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: tb/test_dma_chan_ctl.sv
module test_dma_chan_ctl;
  localparam int CNT_W = 16;
  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic eng_busy = 0, ev_desc_done = 0, ev_desc_cpl = 0, ev_desc_stop = 0;
  logic ev_align = 0, ev_magic = 0, ev_badlen = 0;
  logic err_read = 0, err_write = 0, err_desc = 0;
  logic eng_go, cfg_rd_fixed, cfg_stream_wb_off, wb_req, irq;
  logic [CNT_W-1:0] wb_count;

  int total = 0, bad = 0;
  int exp_q[$];
  int sb_cnt = 0;
  bit poll_on = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  dma_chan_ctl i_dma_chan_ctl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_busy(eng_busy),
    .ev_desc_done(ev_desc_done), .ev_desc_cpl(ev_desc_cpl), .ev_desc_stop(ev_desc_stop),
    .ev_align(ev_align), .ev_magic(ev_magic), .ev_badlen(ev_badlen),
    .err_read(err_read), .err_write(err_write), .err_desc(err_desc),
    .eng_go(eng_go), .cfg_rd_fixed(cfg_rd_fixed), .cfg_stream_wb_off(cfg_stream_wb_off),
    .wb_req(wb_req), .wb_count(wb_count), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 4'(a); reg_wdata = d;
    if (a == 0 && d[0] && !poll_on) sb_cnt = 0;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rdreg(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = 4'(a);
    @(negedge clk);
    reg_rd = 0; d = reg_rdata;
  endtask

  // scoreboard driver: one descriptor completion
  task automatic done_pulse(input bit cpl);
    @(negedge clk);
    ev_desc_done = 1; ev_desc_cpl = cpl;
    sb_cnt++;
    if (poll_on && cpl) exp_q.push_back(sb_cnt);
    @(negedge clk);
    ev_desc_done = 0; ev_desc_cpl = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && wb_req) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R8 unexpected wb_req actual=%0d expected=none", wb_count);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(wb_count) != e) begin
          bad++;
          $display("FAIL R8 wb_count actual=%0d expected=%0d", wb_count, e);
        end
      end
    end
  end

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  localparam logic [31:0] ALL_EN = 32'h00FF_FE7E;

  initial begin
    cyc(3); rst = 0; cyc(1);
    // R10 reset state
    chk("R10 go", 32'(eng_go), 0);
    chk("R10 irq", 32'(irq), 0);
    rdreg(0, rd); chk("R10 ctrl", rd, 0);
    rdreg(1, rd); chk("R10 status", rd, 0);

    // R9 readback masking and config outputs
    wr(0, 32'hFFFF_FFFE);
    rdreg(0, rd); chk("R9 ctrl readback", rd, 32'h0EFF_FE7E);
    chk("R9 rd_fixed", 32'(cfg_rd_fixed), 1);
    chk("R9 stream_wb_off", 32'(cfg_stream_wb_off), 1);
    wr(0, 0);
    rdreg(0, rd); chk("R9 ctrl cleared", rd, 0);

    // R1 start with poll mode, all enables
    wr(2, 32'h1FF);
    sb_cnt = 0; poll_on = 1;
    wr(0, ALL_EN | 32'h0400_0001);
    cyc(1); chk("R1 go after start", 32'(eng_go), 1);
    rdreg(3, rd); chk("R1 count cleared", rd, 0);

    // R5, R7 enabled event and irq
    @(negedge clk) ev_align = 1; @(negedge clk) ev_align = 0;
    cyc(2);
    rdreg(1, rd); chk("R5 align logged", rd, 32'h004);
    chk("R7 irq up", 32'(irq), 1);
    // R6 clear on write-one
    wr(1, 32'h004); cyc(2);
    rdreg(1, rd); chk("R6 w1c", rd, 0);
    chk("R7 irq down", 32'(irq), 0);

    // R8 writeback counts
    done_pulse(1); done_pulse(0); done_pulse(1);
    cyc(2);
    rdreg(3, rd); chk("R8 count reg", rd, 3);
    rdreg(1, rd); chk("R5 desc completed logged", rd, 32'h002);
    wr(1, 32'h1FF);

    // R4 read error with field 0x1E is ignored
    wr(0, 32'h04FF_FC7F);
    @(negedge clk) err_read = 1; @(negedge clk) err_read = 0;
    cyc(2);
    chk("R4 partial enable keeps go", 32'(eng_go), 1);
    rdreg(1, rd); chk("R4 partial enable no log", rd, 0);

    // R4 write error fully enabled halts
    @(negedge clk) err_write = 1; @(negedge clk) err_write = 0;
    cyc(3);
    chk("R4 halt", 32'(eng_go), 0);
    rdreg(1, rd); chk("R4 write err + idle stop", rd, 32'h0A0);
    wr(1, 32'h1FF);

    // R1 restart clears counter
    wr(0, ALL_EN | 32'h0400_0000);
    sb_cnt = 0;
    wr(0, ALL_EN | 32'h0400_0001);
    cyc(1);
    rdreg(3, rd); chk("R1 counter restart", rd, 0);
    chk("R1 go restart", 32'(eng_go), 1);

    // R3 soft stop while busy
    eng_busy = 1;
    wr(0, ALL_EN | 32'h0400_0000);
    cyc(4);
    chk("R3 go held while draining", 32'(eng_go), 1);
    done_pulse(0);
    eng_busy = 0;
    cyc(2);
    chk("R3 go dropped", 32'(eng_go), 0);
    rdreg(1, rd); chk("R3 idle stop logged", rd, 32'h020);
    wr(1, 32'h1FF);

    // R2 soft stop while idle
    sb_cnt = 0;
    wr(0, ALL_EN | 32'h0400_0001);
    cyc(1);
    wr(0, ALL_EN);
    poll_on = 0;
    cyc(2);
    chk("R2 go dropped", 32'(eng_go), 0);
    rdreg(1, rd); chk("R2 idle stop", rd, 32'h020);
    wr(1, 32'h1FF);

    // R5 disabled event ignored (align enable is ctrl bit 3)
    wr(0, ALL_EN & ~32'h8);
    @(negedge clk) ev_align = 1; @(negedge clk) ev_align = 0;
    cyc(2);
    rdreg(1, rd); chk("R5 disabled align ignored", rd, 0);

    // R8 poll off: no request expected
    done_pulse(1);
    cyc(3);
    chk("R8 queue drained", 32'(exp_q.size()), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule